// File: doc/BRIEF.md
# Segment Table Translation Unit

This unit turns a logical address into a physical one. A logical address is made of a segment number and an offset within that segment. The unit keeps a table of sixteen segment descriptors. Each descriptor holds a 32-bit start address (base), a 20-bit segment length (limit), a validation bit and three access-privilege bits. It also keeps a count register that gives how many segments the running program may use.

Software loads the descriptors and the count through a register-write port. The processor side presents one translation request per cycle, made of a segment number, an offset and an access kind. One cycle later the unit answers with either the relocated address or a trap code. The trap code names the first legality check that failed. The checks are made in a fixed order: the segment count, the validation bit, the segment length, and last the access privilege.

Top module: `seg_xlate`

## Requirements
- R1: After a synchronous active-high reset, rsp_valid is 0, the count register is 0 and every descriptor is marked invalid, so the first request traps with code 1.
- R2: rsp_valid is 1 in exactly the cycles that follow a cycle with req_valid high. While rsp_valid is 0, rsp_paddr and rsp_trap read 0.
- R3: A segment number that is greater than or equal to the count register, or greater than or equal to 16, gives trap code 1.
- R4: A segment whose validation bit is 0 gives trap code 2.
- R5: An offset that is greater than or equal to the segment's limit gives trap code 3.
- R6: The access kind is encoded as 0 = read, 1 = write, 2 = execute and 3 = reserved. The privilege field uses bit 0 for read, bit 1 for write and bit 2 for execute. An access whose bit is clear gives trap code 4. The reserved kind is always refused.
- R7: When several checks fail, only the first one in the order count, validation, limit, privilege is reported.
- R8: A legal access gives trap code 0 and rsp_paddr equal to base plus the zero-extended offset, taken modulo 2^32.
- R9: When the trap code is not 0, rsp_paddr is 0.
- R10: A descriptor write stores base, limit, validation bit and privilege field at index cfg_idx. A request made in the same cycle as the write still sees the old descriptor, and the next request sees the new one.
- R11: A count write loads cfg_len. A request made in the same cycle still uses the old count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_ent_we | input | 1 | Write strobe for a descriptor |
| cfg_idx | input | 4 | Index of the descriptor to write |
| cfg_base | input | 32 | Base address to store |
| cfg_limit | input | 20 | Segment length to store |
| cfg_valid | input | 1 | Validation bit to store |
| cfg_perm | input | 3 | Privilege bits to store (bit 0 read, bit 1 write, bit 2 execute) |
| cfg_len_we | input | 1 | Write strobe for the count register |
| cfg_len | input | 5 | New segment count |
| req_valid | input | 1 | Translation request present |
| req_seg | input | 5 | Segment number |
| req_off | input | 20 | Offset within the segment |
| req_acc | input | 2 | Access kind |
| rsp_valid | output | 1 | Result present |
| rsp_paddr | output | 32 | Physical address, 0 on a trap |
| rsp_trap | output | 3 | Trap code (0 means none) |

## Verification
A configuration write and a translation can fall in the same clock edge. They can even target the same descriptor or the count register. The bench provokes this by driving a descriptor write and a request on the same segment in one cycle. It also drives a count write together with a request just at the boundary. The response to that first request must match the bench's model of the old table. A second request, made right after, must match the new one.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    localparam int ENTRIES = 16;
    localparam int IDX_W   = $clog2(ENTRIES);
    localparam int SEG_W   = IDX_W + 1;
    localparam int LEN_W   = $clog2(ENTRIES + 1);
    localparam int BASE_W  = 32;
    localparam int LIM_W   = 20;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [2:0] {
        TRAP_NONE  = 3'd0,
        TRAP_RANGE = 3'd1,
        TRAP_INVAL = 3'd2,
        TRAP_LIMIT = 3'd3,
        TRAP_PERM  = 3'd4
    } trap_e;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic [LIM_W-1:0]  limit;
        logic              valid;
        logic [2:0]        perm;
    } desc_t;

    typedef struct packed {
        trap_e             trap;
        logic [BASE_W-1:0] paddr;
    } xres_t;

    function automatic logic acc_allowed(input logic [2:0] perm, input acc_e acc);
        case (acc)
            ACC_READ:  return perm[0];
            ACC_WRITE: return perm[1];
            ACC_EXEC:  return perm[2];
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/seg_table.sv
module seg_table
    import seg_xlate_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ent_we,
    input  logic [IDX_W-1:0] ent_idx,
    input  desc_t            ent_d,
    input  logic             len_we,
    input  logic [LEN_W-1:0] len_d,
    input  logic [SEG_W-1:0] rd_seg,
    output desc_t            rd_desc,
    output logic [LEN_W-1:0] len_q
);

    desc_t store_q [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                store_q[g] <= '0;
            end else if (ent_we && ent_idx == IDX_W'(g)) begin
                store_q[g] <= ent_d;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            len_q <= '0;
        end else if (len_we) begin
            len_q <= len_d;
        end
    end

    always_comb begin
        if (rd_seg < SEG_W'(ENTRIES)) begin
            rd_desc = store_q[rd_seg[IDX_W-1:0]];
        end else begin
            rd_desc = '0;
        end
    end

endmodule

// File: rtl/seg_check.sv
module seg_check
    import seg_xlate_pkg::*;
(
    input  desc_t            desc,
    input  logic [LEN_W-1:0] seg_len,
    input  logic [SEG_W-1:0] seg,
    input  logic [LIM_W-1:0] off,
    input  acc_e             acc,
    output xres_t            res
);

    logic in_count;

    assign in_count = (seg < SEG_W'(ENTRIES)) && (SEG_W'(seg) < SEG_W'(seg_len));

    always_comb begin
        res = '{trap: TRAP_NONE, paddr: '0};
        if (!in_count) begin
            res.trap = TRAP_RANGE;
        end else if (!desc.valid) begin
            res.trap = TRAP_INVAL;
        end else if (off >= desc.limit) begin
            res.trap = TRAP_LIMIT;
        end else if (!acc_allowed(desc.perm, acc)) begin
            res.trap = TRAP_PERM;
        end else begin
            res.paddr = desc.base + BASE_W'(off);
        end
    end

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
    import seg_xlate_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         cfg_ent_we,
    input  logic [3:0]   cfg_idx,
    input  logic [31:0]  cfg_base,
    input  logic [19:0]  cfg_limit,
    input  logic         cfg_valid,
    input  logic [2:0]   cfg_perm,
    input  logic         cfg_len_we,
    input  logic [4:0]   cfg_len,
    input  logic         req_valid,
    input  logic [4:0]   req_seg,
    input  logic [19:0]  req_off,
    input  logic [1:0]   req_acc,
    output logic         rsp_valid,
    output logic [31:0]  rsp_paddr,
    output logic [2:0]   rsp_trap
);

    desc_t            wr_desc;
    desc_t            rd_desc;
    logic [LEN_W-1:0] len_q;
    xres_t            res_d;
    xres_t            res_q;
    logic             vld_q;

    assign wr_desc = '{base: cfg_base, limit: cfg_limit, valid: cfg_valid, perm: cfg_perm};

    seg_table u_tbl (
        .clk     (clk),
        .rst     (rst),
        .ent_we  (cfg_ent_we),
        .ent_idx (cfg_idx),
        .ent_d   (wr_desc),
        .len_we  (cfg_len_we),
        .len_d   (cfg_len),
        .rd_seg  (req_seg),
        .rd_desc (rd_desc),
        .len_q   (len_q)
    );

    seg_check u_chk_logic (
        .desc    (rd_desc),
        .seg_len (len_q),
        .seg     (req_seg),
        .off     (req_off),
        .acc     (acc_e'(req_acc)),
        .res     (res_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            res_q <= '{trap: TRAP_NONE, paddr: '0};
        end else begin
            vld_q <= req_valid;
            res_q <= req_valid ? res_d : '{trap: TRAP_NONE, paddr: '0};
        end
    end

    assign rsp_valid = vld_q;
    assign rsp_paddr = res_q.paddr;
    assign rsp_trap  = res_q.trap;

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk (
    input logic        clk,
    input logic        rst,
    input logic        cfg_ent_we,
    input logic [3:0]  cfg_idx,
    input logic        cfg_valid,
    input logic        cfg_len_we,
    input logic [4:0]  cfg_len,
    input logic        req_valid,
    input logic [4:0]  req_seg,
    input logic        rsp_valid,
    input logic [31:0] rsp_paddr,
    input logic [2:0]  rsp_trap
);

    logic [4:0]  sh_len;
    logic [15:0] sh_vld;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_len <= '0;
            sh_vld <= '0;
        end else begin
            if (cfg_len_we) sh_len <= cfg_len;
            if (cfg_ent_we) sh_vld[cfg_idx] <= cfg_valid;
        end
    end

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid) else $error("rsp missing"); // R2
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid) else $error("spurious rsp"); // R2
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> (rsp_trap == 3'd0 && rsp_paddr == 32'd0)) else $error("idle not zero"); // R2
    AST_COUNT_GATE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (req_seg >= sh_len || req_seg >= 5'd16)) |=> rsp_trap == 3'd1) else $error("count gate"); // R3
    AST_INVALID_TRAPS: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_seg < sh_len && req_seg < 5'd16 && !sh_vld[req_seg[3:0]]) |=> rsp_trap == 3'd2)
        else $error("invalid entry"); // R4
    AST_TRAP_ZERO_ADDR: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_trap != 3'd0) |-> rsp_paddr == 32'd0) else $error("trap addr"); // R9
    AST_TRAP_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        rsp_trap <= 3'd4) else $error("trap code"); // R7

endmodule

bind seg_xlate seg_xlate_chk u_sva (
    .clk        (clk),
    .rst        (rst),
    .cfg_ent_we (cfg_ent_we),
    .cfg_idx    (cfg_idx),
    .cfg_valid  (cfg_valid),
    .cfg_len_we (cfg_len_we),
    .cfg_len    (cfg_len),
    .req_valid  (req_valid),
    .req_seg    (req_seg),
    .rsp_valid  (rsp_valid),
    .rsp_paddr  (rsp_paddr),
    .rsp_trap   (rsp_trap)
);

// File: tb/seg_xlate_tb.sv
`timescale 1ns/1ps
module seg_xlate_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_ent_we;
    logic [3:0]  cfg_idx;
    logic [31:0] cfg_base;
    logic [19:0] cfg_limit;
    logic        cfg_valid;
    logic [2:0]  cfg_perm;
    logic        cfg_len_we;
    logic [4:0]  cfg_len;
    logic        req_valid;
    logic [4:0]  req_seg;
    logic [19:0] req_off;
    logic [1:0]  req_acc;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic [2:0]  rsp_trap;

    int n_run  = 0;
    int n_fail = 0;

    logic [31:0] m_base [16];
    logic [19:0] m_lim  [16];
    logic        m_vld  [16];
    logic [2:0]  m_perm [16];
    logic [4:0]  m_len;

    always #2.5 clk = ~clk;

    seg_xlate u_dut (.*);

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    function automatic string tag_of(input logic [2:0] t);
        case (t)
            3'd0: return "R8";
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R5";
            default: return "R6";
        endcase
    endfunction

    function automatic logic [34:0] model(input logic [4:0] s, input logic [19:0] o, input logic [1:0] a);
        logic ok;
        if (s >= m_len || s >= 5'd16) return {3'd1, 32'd0};
        if (!m_vld[s[3:0]]) return {3'd2, 32'd0};
        if (o >= m_lim[s[3:0]]) return {3'd3, 32'd0};
        case (a)
            2'd0: ok = m_perm[s[3:0]][0];
            2'd1: ok = m_perm[s[3:0]][1];
            2'd2: ok = m_perm[s[3:0]][2];
            default: ok = 1'b0;
        endcase
        if (!ok) return {3'd4, 32'd0};
        return {3'd0, m_base[s[3:0]] + {12'd0, o}};
    endfunction

    task automatic put_entry(input int i, input logic [31:0] b, input logic [19:0] l,
                             input logic v, input logic [2:0] p);
        @(negedge clk);
        cfg_ent_we = 1'b1; cfg_idx = 4'(i); cfg_base = b; cfg_limit = l;
        cfg_valid = v; cfg_perm = p;
        @(negedge clk);
        cfg_ent_we = 1'b0;
        m_base[i] = b; m_lim[i] = l; m_vld[i] = v; m_perm[i] = p;
    endtask

    task automatic put_len(input logic [4:0] n);
        @(negedge clk);
        cfg_len_we = 1'b1; cfg_len = n;
        @(negedge clk);
        cfg_len_we = 1'b0;
        m_len = n;
    endtask

    task automatic check(input logic [2:0] et, input logic [31:0] ea, input string why);
        n_run++;
        if (!rsp_valid || rsp_trap !== et || rsp_paddr !== ea) begin
            n_fail++;
            $display("FAIL %s: valid=%0b trap=%0d paddr=%h expected trap=%0d paddr=%h",
                     why, rsp_valid, rsp_trap, rsp_paddr, et, ea);
        end
    endtask

    task automatic xlate(input logic [4:0] s, input logic [19:0] o, input logic [1:0] a, input string why);
        logic [34:0] e;
        e = model(s, o, a);
        @(negedge clk);
        req_valid = 1'b1; req_seg = s; req_off = o; req_acc = a;
        @(negedge clk);
        req_valid = 1'b0;
        check(e[34:32], e[31:0], why);
    endtask

    task automatic sweep();
        for (int s = 0; s < 18; s++) begin
            for (int a = 0; a < 4; a++) begin
                logic [19:0] l;
                l = m_lim[s % 16];
                xlate(5'(s), 20'd0, 2'(a), "sweep");
                xlate(5'(s), l - 20'd1, 2'(a), "sweep");
                xlate(5'(s), l, 2'(a), "sweep R5 boundary");
                xlate(5'(s), l + 20'd3, 2'(a), "sweep");
                xlate(5'(s), 20'hFFFFE, 2'(a), "sweep");
            end
        end
    endtask

    initial begin
        logic [34:0] e;
        rst = 1'b1; cfg_ent_we = 0; cfg_idx = 0; cfg_base = 0; cfg_limit = 0;
        cfg_valid = 0; cfg_perm = 0; cfg_len_we = 0; cfg_len = 0;
        req_valid = 0; req_seg = 0; req_off = 0; req_acc = 0;
        for (int i = 0; i < 16; i++) begin
            m_base[i] = 0; m_lim[i] = 0; m_vld[i] = 0; m_perm[i] = 0;
        end
        m_len = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 / R2: reset state and idle outputs
        n_run++;
        if (rsp_valid !== 1'b0 || rsp_trap !== 3'd0 || rsp_paddr !== 32'd0) begin
            n_fail++;
            $display("FAIL R1: valid=%0b trap=%0d paddr=%h expected 0 0 0", rsp_valid, rsp_trap, rsp_paddr);
        end
        xlate(5'd0, 20'd0, 2'd0, "R1 empty count");
        n_run++;
        @(negedge clk);
        if (rsp_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R2: valid=%0b expected 0 when idle", rsp_valid);
        end

        // R10: load table
        for (int i = 0; i < 16; i++) begin
            logic [31:0] b;
            logic [19:0] l;
            b = (i == 15) ? 32'hFFFF_F000 : 32'h0010_0000 * i + 32'h40 * i;
            l = (i == 15) ? 20'hFFFFF : 20'h00100 * 20'(i + 1);
            put_entry(i, b, l, (i != 5 && i != 10), 3'(i));
        end
        put_len(5'd12);
        // R3..R9: sweep with count 12
        sweep();
        // R11: full count, includes base wrap in entry 15 (R8)
        put_len(5'd16);
        sweep();
        xlate(5'd15, 20'hFFFFE, 2'd0, "R8 wrap");

        // R7: priority with all checks failing at once
        put_entry(4, 32'h1234_0000, 20'h10, 1'b0, 3'b000);
        xlate(5'd4, 20'h20, 2'd3, "R7 invalid over limit");
        put_entry(4, 32'h1234_0000, 20'h10, 1'b1, 3'b000);
        xlate(5'd4, 20'h20, 2'd1, "R7 limit over perm");
        put_len(5'd4);
        xlate(5'd4, 20'h20, 2'd1, "R7 count first");

        // R10: write and request in the same cycle
        put_len(5'd16);
        e = model(5'd2, 20'h8, 2'd0);
        @(negedge clk);
        cfg_ent_we = 1'b1; cfg_idx = 4'd2; cfg_base = 32'hABCD_0000; cfg_limit = 20'h40;
        cfg_valid = 1'b1; cfg_perm = 3'b001;
        req_valid = 1'b1; req_seg = 5'd2; req_off = 20'h8; req_acc = 2'd0;
        @(negedge clk);
        cfg_ent_we = 1'b0; req_valid = 1'b0;
        m_base[2] = 32'hABCD_0000; m_lim[2] = 20'h40; m_vld[2] = 1'b1; m_perm[2] = 3'b001;
        check(e[34:32], e[31:0], "R10 old descriptor");
        xlate(5'd2, 20'h8, 2'd0, "R10 new descriptor");

        // R11: count write and request in the same cycle
        e = model(5'd7, 20'h4, 2'd0);
        @(negedge clk);
        cfg_len_we = 1'b1; cfg_len = 5'd7;
        req_valid = 1'b1; req_seg = 5'd7; req_off = 20'h4; req_acc = 2'd0;
        @(negedge clk);
        cfg_len_we = 1'b0; req_valid = 1'b0;
        m_len = 5'd7;
        check(e[34:32], e[31:0], "R11 old count");
        xlate(5'd7, 20'h4, 2'd0, "R11 new count");
        xlate(5'd6, 20'h4, 2'd0, "R11 below count");

        // back-to-back requests, R2
        @(negedge clk);
        req_valid = 1'b1; req_seg = 5'd6; req_off = 20'h1; req_acc = 2'd0;
        @(negedge clk);
        req_seg = 5'd9;
        e = model(5'd6, 20'h1, 2'd0);
        check(e[34:32], e[31:0], "R2 back-to-back first");
        @(negedge clk);
        req_valid = 1'b0;
        e = model(5'd9, 20'h1, 2'd0);
        check(e[34:32], e[31:0], "R2 back-to-back second");

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule